// File: doc/BRIEF.md
# Auto-MDIX Link Resolver

This block brings up a twisted-pair LAN port whose cable may be straight or crossed. It owns one select output that chooses normal (MDI) or crossover (MDIX) pin assignment. It owns no management bus of its own. It talks to a separate MDIO access controller through a one-cycle request, a register address, a busy flag and a read-data word. After a start pulse it waits one retry period and then reads the PHY basic status register. If the link is still down it flips the crossover select and tries again. It gives up after a fixed number of attempts.

Once the link is reported up, the resolver reads the status register again. If auto-negotiation has completed, it reads the vendor speed register and decodes the speed and duplex. When the local PHY can also auto-negotiate, it resolves pause capability through a chain of up to three further reads. The result is a 4-bit status word, held together with a done or fail flag until the next start. The retry period is a cycle-count parameter, so a bench can shrink it.

Top module: `mdix_link_resolver`

## Requirements
- R1: After reset, mdix_sel, done, fail, mdio_req and link_status are all 0.
- R2: On start the select goes low (MDI). The first read request, to register 1, follows after RETRY_TICKS cycles plus a few cycles of pipeline. Every request is a single-cycle mdio_req with a stable mdio_reg, and the read data is taken only once mdio_busy is low again. mdio_phy always carries PHY_ADDR.
- R3: A register 1 read with bit 2 set means the link is up. With bit 2 clear the link is down.
- R4: Each failed poll inverts mdix_sel, and the next poll follows after another retry period. Poll n (counting from 0) is therefore made with mdix_sel equal to n mod 2.
- R5: After MAX_TRIES failed polls, fail is raised, link_status stays 0 and no further request is issued.
- R6: After a successful poll, register 1 is read again. Only if bit 5 of that reread is set is register 31 read. Its bits 4:2 are decoded as follows: 1 gives 10 Mb/s half duplex, 5 gives 10 Mb/s full, 2 gives 100 Mb/s half and 6 gives 100 Mb/s full. In link_status, bit 0 is link, bit 1 is 100 Mb/s, bit 2 is full duplex and bit 3 is pause.
- R7: Whenever the link is up, done is raised with link_status bit 0 set. Bits 1 and 2 stay 0 when bit 5 is clear or when the speed code is any other value.
- R8: Pause is resolved only when the reread has both bit 5 and bit 3 set. The resolver reads register 6 and continues only if its bit 0 is set. It then reads register 4 and continues only if its bit 10 is set. It then reads register 5, and that register's bit 10 becomes the pause flag. The chain stops at the first clear bit, and the pause flag stays 0.
- R9: done or fail, together with link_status, is held with no further requests until the next start. A start that arrives while resolution is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution run (accepted when idle, done or failed) |
| mdix_sel | output | 1 | Crossover select, 0 = MDI, 1 = MDIX |
| mdio_req | output | 1 | One-cycle read request to the MDIO controller |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register address of the request |
| mdio_busy | input | 1 | Controller busy; rises on the edge that takes the request |
| mdio_rdata | input | 16 | Read data, valid once busy is low |
| done | output | 1 | Link resolved; status valid |
| fail | output | 1 | Retries exhausted without link |
| link_status | output | 4 | {pause, full duplex, 100 Mb/s, link} |

## Verification
Two events can coincide: a fresh start pulse and a resolution run that is still in progress, with a read in flight or a retry period counting. The bench provokes this by pulsing start a few cycles after the first request of a multi-poll run. It then judges the whole request-address sequence, the select value seen at every poll, and the final status against the expected values computed for an undisturbed run. The controller model also randomises busy length, so the release of busy falls at varying distances from state changes in the resolver.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_POLL, ST_RECHK, ST_SPD,
        ST_ANX, ST_ADV, ST_LPA, ST_DONE, ST_FAIL
    } res_state_e;

    typedef enum logic [1:0] {PT_IDLE, PT_ISSUE, PT_WAIT} port_state_e;

    typedef struct packed {
        logic pause;
        logic full;
        logic fast;
        logic link;
    } link_stat_t;

    localparam logic [4:0] REG_BSR = 5'd1;
    localparam logic [4:0] REG_SPD = 5'd31;
    localparam logic [4:0] REG_ANX = 5'd6;
    localparam logic [4:0] REG_ADV = 5'd4;
    localparam logic [4:0] REG_LPA = 5'd5;

    localparam int BIT_LINK    = 2;
    localparam int BIT_ANABLE  = 3;
    localparam int BIT_ANDONE  = 5;
    localparam int BIT_PEER_AN = 0;
    localparam int BIT_PAUSE   = 10;

    function automatic link_stat_t decode_speed(input logic [2:0] code);
        link_stat_t s;
        s = '0;
        case (code)
            3'd5: s.full = 1'b1;
            3'd2: s.fast = 1'b1;
            3'd6: begin s.fast = 1'b1; s.full = 1'b1; end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mdix_tick_timer.sv
module mdix_tick_timer #(
    parameter int unsigned TICKS = 200_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic expired
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (go) begin
                run <= 1'b1;
                cnt <= CW'(TICKS - 1);
            end else if (run) begin
                if (cnt == '0) begin
                    run     <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);

endmodule

// File: rtl/mdix_rd_port.sv
module mdix_rd_port
    import mdix_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    output logic          mdio_req,
    output logic [AW-1:0] mdio_reg,
    input  logic          mdio_busy,
    input  logic [DW-1:0] mdio_rdata,
    output logic          rd_done,
    output logic [DW-1:0] rd_data
);
    port_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PT_IDLE;
            mdio_req <= 1'b0;
            mdio_reg <= '0;
            rd_done  <= 1'b0;
            rd_data  <= '0;
        end else begin
            mdio_req <= 1'b0;
            rd_done  <= 1'b0;
            case (st)
                PT_IDLE: if (rd_go) begin
                    mdio_req <= 1'b1;
                    mdio_reg <= rd_addr;
                    st       <= PT_ISSUE;
                end
                PT_ISSUE: st <= PT_WAIT;
                PT_WAIT: if (!mdio_busy) begin
                    rd_done <= 1'b1;
                    rd_data <= mdio_rdata;
                    st      <= PT_IDLE;
                end
                default: st <= PT_IDLE;
            endcase
        end
    end

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        mdio_req |=> !mdio_req);
    p_reg_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (st == PT_WAIT) |=> $stable(mdio_reg));

endmodule

// File: rtl/mdix_link_resolver.sv
module mdix_link_resolver
    import mdix_pkg::*;
#(
    parameter int unsigned RETRY_TICKS = 200_000_000,
    parameter int unsigned MAX_TRIES   = 100,
    parameter int unsigned PHY_ADDR    = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        mdix_sel,
    output logic        mdio_req,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    input  logic        mdio_busy,
    input  logic [15:0] mdio_rdata,
    output logic        done,
    output logic        fail,
    output logic [3:0]  link_status
);
    localparam int TW = $clog2(MAX_TRIES + 1);

    res_state_e    state;
    logic [TW-1:0] tries;
    logic          tmr_go, tmr_exp;
    logic          rd_go, rd_done;
    logic [4:0]    rd_addr;
    logic [15:0]   rd_data;
    logic          an_able;
    link_stat_t    stat, spd;
    logic          unused_bits;

    assign unused_bits = ^{rd_data[15:11], rd_data[9:6], rd_data[1]};
    assign spd         = decode_speed(rd_data[4:2]);

    mdix_tick_timer #(.TICKS(RETRY_TICKS)) tmr_i (
        .clk(clk), .rst(rst), .go(tmr_go), .expired(tmr_exp)
    );

    mdix_rd_port #(.AW(5), .DW(16)) port_i (
        .clk(clk), .rst(rst), .rd_go(rd_go), .rd_addr(rd_addr),
        .mdio_req(mdio_req), .mdio_reg(mdio_reg), .mdio_busy(mdio_busy),
        .mdio_rdata(mdio_rdata), .rd_done(rd_done), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mdix_sel <= 1'b0;
            tries    <= '0;
            tmr_go   <= 1'b0;
            rd_go    <= 1'b0;
            rd_addr  <= '0;
            an_able  <= 1'b0;
            stat     <= '0;
        end else begin
            tmr_go <= 1'b0;
            rd_go  <= 1'b0;
            case (state)
                ST_IDLE, ST_DONE, ST_FAIL: if (start) begin
                    mdix_sel <= 1'b0;
                    tries    <= '0;
                    an_able  <= 1'b0;
                    stat     <= '0;
                    tmr_go   <= 1'b1;
                    state    <= ST_WAIT;
                end
                ST_WAIT: if (tmr_exp) begin
                    rd_go   <= 1'b1;
                    rd_addr <= REG_BSR;
                    state   <= ST_POLL;
                end
                ST_POLL: if (rd_done) begin
                    if (rd_data[BIT_LINK]) begin
                        rd_go   <= 1'b1;
                        rd_addr <= REG_BSR;
                        state   <= ST_RECHK;
                    end else begin
                        mdix_sel <= ~mdix_sel;
                        if (tries == TW'(MAX_TRIES - 1)) begin
                            state <= ST_FAIL;
                        end else begin
                            tries  <= tries + 1'b1;
                            tmr_go <= 1'b1;
                            state  <= ST_WAIT;
                        end
                    end
                end
                ST_RECHK: if (rd_done) begin
                    stat.link <= 1'b1;
                    an_able   <= rd_data[BIT_ANABLE];
                    if (rd_data[BIT_ANDONE]) begin
                        rd_go   <= 1'b1;
                        rd_addr <= REG_SPD;
                        state   <= ST_SPD;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_SPD: if (rd_done) begin
                    stat.fast <= spd.fast;
                    stat.full <= spd.full;
                    if (an_able) begin
                        rd_go   <= 1'b1;
                        rd_addr <= REG_ANX;
                        state   <= ST_ANX;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_ANX: if (rd_done) begin
                    if (rd_data[BIT_PEER_AN]) begin
                        rd_go   <= 1'b1;
                        rd_addr <= REG_ADV;
                        state   <= ST_ADV;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_ADV: if (rd_done) begin
                    if (rd_data[BIT_PAUSE]) begin
                        rd_go   <= 1'b1;
                        rd_addr <= REG_LPA;
                        state   <= ST_LPA;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_LPA: if (rd_done) begin
                    stat.pause <= rd_data[BIT_PAUSE];
                    state      <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done        = (state == ST_DONE);
    assign fail        = (state == ST_FAIL);
    assign link_status = done ? stat : 4'b0000;
    assign mdio_phy    = 5'(PHY_ADDR);

    p_done_link_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> link_status[0]);
    p_fail_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        fail |-> (!mdio_req && link_status == 4'b0000));
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> $stable(mdix_sel));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !mdio_req));

endmodule

// File: tb/mdix_link_resolver_tb_top.sv
module mdix_link_resolver_tb_top;
    localparam int RT = 20;
    localparam int MT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mdix_sel, mdio_req, mdio_busy, done, fail;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_rdata;
    logic [3:0]  link_status;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    mdix_link_resolver #(.RETRY_TICKS(RT), .MAX_TRIES(MT), .PHY_ADDR(6)) dut_i (
        .clk(clk), .rst(rst), .start(start), .mdix_sel(mdix_sel),
        .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
        .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata), .done(done),
        .fail(fail), .link_status(link_status)
    );

    // scenario and controller model
    int          link_at;
    logic [15:0] r1_base, r31, r6, r4, r5;
    logic [4:0]  addr_log [0:63];
    int          n_req, n_bsr, lat;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mdio_busy  <= 1'b0;
            mdio_rdata <= '0;
            lat        <= 0;
        end else if (mdio_busy) begin
            if (lat == 0) mdio_busy <= 1'b0;
            else lat <= lat - 1;
        end else if (mdio_req) begin
            mdio_busy <= 1'b1;
            lat       <= $urandom_range(0, 3);
            if (n_req < 64) addr_log[n_req] = mdio_reg;
            n_req = n_req + 1;
            case (mdio_reg)
                5'd1: begin
                    if (n_bsr <= link_at && n_bsr < MT)
                        chk(mdix_sel == n_bsr[0], "R4", "select at poll",
                            int'(mdix_sel), n_bsr % 2);
                    mdio_rdata <= (n_bsr >= link_at) ? (r1_base | 16'h0004) : r1_base;
                    n_bsr = n_bsr + 1;
                end
                5'd31:   mdio_rdata <= r31;
                5'd6:    mdio_rdata <= r6;
                5'd4:    mdio_rdata <= r4;
                5'd5:    mdio_rdata <= r5;
                default: mdio_rdata <= 16'hDEAD;
            endcase
        end
    end

    // expected values, from the requirements
    logic [4:0] exp_addr [0:63];
    int         exp_n;
    bit         exp_fail;
    logic [3:0] exp_stat;

    task automatic add_exp(input logic [4:0] a);
        exp_addr[exp_n] = a;
        exp_n++;
    endtask

    task automatic calc_expected();
        int polls;
        exp_n    = 0;
        exp_stat = 4'b0000;
        exp_fail = (link_at >= MT);
        polls    = exp_fail ? MT : link_at + 1;
        for (int i = 0; i < polls; i++) add_exp(5'd1);
        if (!exp_fail) begin
            add_exp(5'd1);
            exp_stat[0] = 1'b1;
            if (r1_base[5]) begin
                add_exp(5'd31);
                case (r31[4:2])
                    3'd5: exp_stat[2] = 1'b1;
                    3'd2: exp_stat[1] = 1'b1;
                    3'd6: begin exp_stat[1] = 1'b1; exp_stat[2] = 1'b1; end
                    default: ;
                endcase
                if (r1_base[3]) begin
                    add_exp(5'd6);
                    if (r6[0]) begin
                        add_exp(5'd4);
                        if (r4[10]) begin
                            add_exp(5'd5);
                            exp_stat[3] = r5[10];
                        end
                    end
                end
            end
        end
    endtask

    task automatic run_scen(input string tag, input bit mid_start);
        int k, t;
        @(negedge clk);
        n_req = 0;
        n_bsr = 0;
        calc_expected();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (n_req == 0 && k < 500) begin @(negedge clk); k++; end
        chk(k >= RT && k <= RT + 8, "R2", {tag, " first poll delay"}, k, RT + 5);
        chk(mdio_phy == 5'd6, "R2", {tag, " phy address"}, mdio_phy, 6);
        if (mid_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && !fail && t < 5000) begin @(negedge clk); t++; end
        chk(fail == exp_fail, exp_fail ? "R5" : "R7", {tag, " fail flag"}, fail, exp_fail);
        chk(done == !exp_fail, "R7", {tag, " done flag"}, done, !exp_fail);
        chk(link_status == exp_stat, exp_stat[3] ? "R8" : "R6", {tag, " status"},
            link_status, exp_stat);
        chk(n_req == exp_n, "R8", {tag, " request count"}, n_req, exp_n);
        for (int i = 0; i < exp_n && i < n_req; i++)
            chk(addr_log[i] == exp_addr[i], "R6", {tag, " request address"},
                addr_log[i], exp_addr[i]);
        if (exp_fail)
            chk(mdix_sel == MT[0], "R4", {tag, " select after fail"}, mdix_sel, MT % 2);
        repeat (40) @(negedge clk);
        chk(n_req == exp_n, "R9", {tag, " no requests while held"}, n_req, exp_n);
        chk(link_status == exp_stat && (done | fail), "R9", {tag, " result held"},
            link_status, exp_stat);
    endtask

    task automatic set_scen(input int la, input logic [15:0] a, input logic [2:0] code,
                            input bit b6, input bit b4, input bit b5);
        link_at = la;
        r1_base = a & 16'hFFFB;
        r31     = {11'h0, code, 2'b01};
        r6      = {15'h1234, b6};
        r4      = {5'h0, b4, 10'h1E1};
        r5      = {5'h0, b5, 10'h0A1};
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        n_req = 0;
        n_bsr = 0;
        set_scen(0, 16'h0, 3'd0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mdix_sel && !done && !fail && !mdio_req && link_status == 0, "R1",
            "reset state", {mdix_sel, done, fail, mdio_req, link_status}, 0);

        set_scen(0, 16'h0028, 3'd6, 1, 1, 1);  run_scen("R3 full pause", 0);
        set_scen(MT, 16'h0028, 3'd6, 1, 1, 1); run_scen("R5 exhaust", 0);
        set_scen(2, 16'h0020, 3'd3, 1, 1, 1);  run_scen("R7 unlisted code", 0);
        set_scen(1, 16'h0008, 3'd6, 1, 1, 1);  run_scen("R7 no andone", 0);
        set_scen(0, 16'h0028, 3'd1, 0, 1, 1);  run_scen("R8 peer no an", 0);
        set_scen(3, 16'h0028, 3'd5, 1, 0, 1);  run_scen("R8 no local pause", 0);
        set_scen(0, 16'h0028, 3'd2, 1, 1, 0);  run_scen("R8 peer no pause", 0);
        set_scen(MT - 1, 16'h0020, 3'd6, 1, 1, 1); run_scen("R4 last try", 0);
        set_scen(3, 16'h0028, 3'd6, 1, 1, 1);  run_scen("R9 mid start", 1);

        for (int n = 0; n < 25; n++) begin
            set_scen($urandom_range(0, MT), 16'($urandom), 3'($urandom),
                     1'($urandom), 1'($urandom), 1'($urandom));
            run_scen("random", n % 5 == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule